// File: doc/BRIEF.md
# Programmable Wait-State Timing Unit

This block works out the cost in clock cycles of each external-memory access and paces the bus to match it. A 16-bit wait-control register holds small code fields. There is one group of fields for each of three ROM windows and one field for a battery-backed SRAM window. From these codes the block derives, for every one of sixteen address regions, the cycle costs of a nonsequential access, a sequential access and a prefetch-assisted access, each at 16-bit and at 32-bit width. The internal-memory regions have fixed costs that the register never changes. Reset clears the register, and the decoded costs are then the power-on defaults.

A requester presents a region number, a width, a sequential flag and a burst length on a valid/ready channel. On acceptance the block latches the total cost of the burst on `cost_total`. It then counts cycles and raises `bus_rdy` for one cycle when the count reaches that total. Only one request is outstanding at a time. `req_ready` stays low from the acceptance edge through the cycle in which `bus_rdy` is high. While `req_ready` is low, the requester must hold its request, and the block takes nothing. A request is taken on a rising edge where `req_valid` and `req_ready` are both high.

Top module: `wait_timing_unit`

## Requirements
- R1: After reset `bus_rdy` is 0, `req_ready` is 1, `cost_total` is 0, and the costs are those of a register value of zero. For example, one 32-bit nonsequential access to region 8 totals 8 cycles.
- R2: For ROM window w (w = 0, 1, 2: regions 8/9, 10/11, 12/13) the first-access field sits at register bits [3w+3:3w+2]. Its codes 0, 1, 2 and 3 give 16-bit nonsequential costs N of 4, 3, 2 and 8.
- R3: For window w the sequential bit is register bit 3w+4. When it is 1, the 16-bit sequential cost S is 1. When it is 0, S is 2, 4 or 8 for window 0, 1 or 2.
- R4: For the ROM windows the 32-bit nonsequential cost is N+1+S and the 32-bit sequential cost is 2S+1.
- R5: Region 14 (SRAM) takes its code from register bits [1:0], using the same four-value mapping. All of its 16-bit costs equal N, and all of its 32-bit costs equal 2N+1.
- R6: When register bit 14 is 1, the prefetch costs of all ROM windows are 0. When it is 0, they equal the sequential cost at the same width. When `req_seq` is 1, the first access of a burst uses the prefetch cost in place of the nonsequential cost.
- R7: A burst of n accesses totals (1 + F) + (n-1)·(1 + S), where F is the first-access cost and S is the sequential cost at the requested width (`req_wide` 1 means 32-bit). A length of 0 counts as 1.
- R8: Region 2 has fixed costs of 2 (16-bit) and 4 (32-bit) for every access kind. Regions 0, 1, 3 to 7 and 15 cost 0. The register affects none of them.
- R9: The two regions of a window, 8+2w and 9+2w, always give the same totals.
- R10: `req_ready` falls on the acceptance edge and rises again only after the `bus_rdy` cycle. A request asserted while `req_ready` is low is not taken.
- R11: `cost_total` shows the burst total from the acceptance edge on. `bus_rdy` is high for exactly one cycle, in the total-th cycle after acceptance.
- R12: A register write takes effect on all costs at its write edge. A burst that is already counting keeps the total it latched when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the wait-control register |
| cfg_data | input | 16 | Wait-control register write data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_region | input | 4 | Region number of the access |
| req_wide | input | 1 | 1 = 32-bit accesses, 0 = 16-bit |
| req_seq | input | 1 | First access continues a sequential stream |
| req_len | input | LEN_W (8) | Number of accesses in the burst, 0 counts as 1 |
| bus_rdy | output | 1 | One-cycle pulse when the burst's cycles have elapsed |
| cost_total | output | LEN_W+5 (13) | Total cycles of the last accepted burst |

## Verification
`cost_total` is due at the first falling-edge sample after the acceptance edge. `bus_rdy` is due at the falling-edge sample whose index, counted from that first one as 1, equals the expected total. The following sample must show `bus_rdy` low and `req_ready` high. The bench counts falling edges from acceptance and compares that index with the total it computes from the register model. This makes an early or late pulse fail even when the reported total is right. Register writes and refused requests are placed at fixed counts inside long bursts, so their effect, or their absence, falls into a known sample.

// File: rtl/wtu_pkg.sv
package wtu_pkg;
  localparam int COST_W      = 5;
  localparam int NUM_REGIONS = 16;
  localparam int NUM_WIN     = 3;
  localparam int WIN_BASE    = 8;
  localparam int SRAM_REGION = 14;
  localparam int FAST_REGION = 2;
  localparam int PF_BIT      = 14;
  localparam int CFG_W       = 16;

  typedef logic [COST_W-1:0] cost_t;

  typedef struct packed {
    cost_t n16;
    cost_t s16;
    cost_t n32;
    cost_t s32;
    cost_t p16;
    cost_t p32;
  } rcost_t;

  // 2-bit first-access code to wait cycles
  function automatic cost_t first_map(input logic [1:0] code);
    case (code)
      2'd0:    return cost_t'(4);
      2'd1:    return cost_t'(3);
      2'd2:    return cost_t'(2);
      default: return cost_t'(8);
    endcase
  endfunction
endpackage

// File: rtl/wtu_cost_table.sv
module wtu_cost_table
  import wtu_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [CFG_W-1:0]                cfg_data,
  output rcost_t [NUM_REGIONS-1:0]        costs
);
  logic [CFG_W-1:0] cfg_q;
  rcost_t           win  [NUM_WIN];
  rcost_t           sram;
  logic             pf_en;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_data;
  end

  assign pf_en = cfg_q[PF_BIT];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    cost_t n, s, s32;
    assign n   = first_map(cfg_q[3*w+2 +: 2]);
    assign s   = cfg_q[3*w+4] ? cost_t'(1) : cost_t'(2 << w);
    assign s32 = cost_t'((s << 1) + 1);
    assign win[w] = '{n16: n, s16: s, n32: cost_t'(n + s + 1), s32: s32,
                      p16: pf_en ? '0 : s, p32: pf_en ? '0 : s32};
  end

  cost_t sn;
  assign sn   = first_map(cfg_q[1:0]);
  assign sram = '{n16: sn, s16: sn, p16: sn,
                  n32: cost_t'((sn << 1) + 1), s32: cost_t'((sn << 1) + 1),
                  p32: cost_t'((sn << 1) + 1)};

  always_comb begin
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (r >= WIN_BASE && r < WIN_BASE + 2*NUM_WIN)
        costs[r] = win[(r - WIN_BASE) >> 1];
      else if (r == SRAM_REGION)
        costs[r] = sram;
      else if (r == FAST_REGION)
        costs[r] = '{n16: cost_t'(2), s16: cost_t'(2), p16: cost_t'(2),
                     n32: cost_t'(4), s32: cost_t'(4), p32: cost_t'(4)};
      else
        costs[r] = '0;
    end
  end

  // R12: write lands in the register at the write edge
  a_r12_cfg_update: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == $past(cfg_data));

  // R9: both aliases of every window carry the same costs
  a_r9_alias_match: assert property (@(posedge clk) disable iff (!rst_n)
    costs[8] == costs[9] && costs[10] == costs[11] && costs[12] == costs[13]);

  // R6: prefetch enabled zeroes window prefetch costs
  a_r6_prefetch_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pf_en |-> (costs[8].p16 == '0 && costs[11].p32 == '0 && costs[12].p32 == '0));

  // R8: fixed internal region is untouched by the register
  a_r8_fast_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> $stable(costs[FAST_REGION]) && costs[0] == '0);
endmodule

// File: rtl/wtu_burst_calc.sv
module wtu_burst_calc
  import wtu_pkg::*;
#(
  parameter int LEN_W = 8,
  localparam int TOT_W = LEN_W + COST_W,
  localparam int REG_W = $clog2(NUM_REGIONS)
) (
  input  rcost_t [NUM_REGIONS-1:0] costs,
  input  logic [REG_W-1:0]         region,
  input  logic                     wide,
  input  logic                     seq,
  input  logic [LEN_W-1:0]         len,
  output logic [TOT_W-1:0]         total
);
  rcost_t           c;
  cost_t            first_c;
  cost_t            rest_c;
  logic [TOT_W-1:0] n_acc;

  always_comb begin
    c       = costs[region];
    if (seq) first_c = wide ? c.p32 : c.p16;
    else     first_c = wide ? c.n32 : c.n16;
    rest_c  = wide ? c.s32 : c.s16;
    n_acc   = (len == '0) ? TOT_W'(1) : TOT_W'(len);
    total   = TOT_W'(first_c) + TOT_W'(1)
            + (n_acc - TOT_W'(1)) * (TOT_W'(rest_c) + TOT_W'(1));
  end
endmodule

// File: rtl/wtu_counter.sv
module wtu_counter #(
  parameter int TOT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TOT_W-1:0] total_in,
  output logic             bus_rdy,
  output logic [TOT_W-1:0] total_q
);
  logic             busy;
  logic [TOT_W-1:0] cnt;
  logic             accept;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign bus_rdy   = busy && (cnt == total_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      total_q <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      cnt     <= TOT_W'(1);
      total_q <= total_in;
    end else if (busy) begin
      if (cnt == total_q) busy <= 1'b0;
      else                cnt  <= cnt + TOT_W'(1);
    end
  end

  a_r11_rdy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdy |=> !bus_rdy);

  a_r10_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  a_r10_rdy_frees: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdy |=> req_ready);

  a_r12_hold_total: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_rdy) |=> $stable(total_q));

  a_r11_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= total_q && cnt != '0));
endmodule

// File: rtl/wait_timing_unit.sv
module wait_timing_unit
  import wtu_pkg::*;
#(
  parameter int LEN_W = 8,
  localparam int TOT_W = LEN_W + COST_W,
  localparam int REG_W = $clog2(NUM_REGIONS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [REG_W-1:0] req_region,
  input  logic             req_wide,
  input  logic             req_seq,
  input  logic [LEN_W-1:0] req_len,
  output logic             bus_rdy,
  output logic [TOT_W-1:0] cost_total
);
  rcost_t [NUM_REGIONS-1:0] costs;
  logic   [TOT_W-1:0]       burst_total;

  wtu_cost_table u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_data (cfg_data),
    .costs    (costs)
  );

  wtu_burst_calc #(.LEN_W(LEN_W)) u_calc (
    .costs  (costs),
    .region (req_region),
    .wide   (req_wide),
    .seq    (req_seq),
    .len    (req_len),
    .total  (burst_total)
  );

  wtu_counter #(.TOT_W(TOT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .total_in  (burst_total),
    .bus_rdy   (bus_rdy),
    .total_q   (cost_total)
  );
endmodule

// File: tb/wait_timing_unit_bench.sv
module wait_timing_unit_bench;
  localparam int LEN_W = 8;
  localparam int TOT_W = LEN_W + 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [15:0]      cfg_data = '0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [3:0]       req_region = '0;
  logic             req_wide = 1'b0;
  logic             req_seq = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic             bus_rdy;
  logic [TOT_W-1:0] cost_total;

  int          n_checks = 0;
  int          n_fail   = 0;
  logic [15:0] cfg_model = '0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  wait_timing_unit #(.LEN_W(LEN_W)) u_wait_timing_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_region(req_region),
    .req_wide(req_wide), .req_seq(req_seq), .req_len(req_len),
    .bus_rdy(bus_rdy), .cost_total(cost_total)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int fmap(input int code);
    case (code & 3)
      0: return 4;
      1: return 3;
      2: return 2;
      default: return 8;
    endcase
  endfunction

  function automatic int exp_total(input logic [15:0] rv, input int region,
                                   input bit wide, input bit seq, input int len);
    int n16 = 0, s16 = 0, n32 = 0, s32 = 0, p16 = 0, p32 = 0;
    int first, rest, cnt;
    if (region == 2) begin
      n16 = 2; s16 = 2; p16 = 2; n32 = 4; s32 = 4; p32 = 4;
    end else if (region >= 8 && region <= 13) begin
      int w = (region - 8) / 2;
      n16 = fmap(int'(rv >> (2 + 3*w)));
      if (rv[4 + 3*w]) s16 = 1;
      else s16 = (w == 0) ? 2 : (w == 1) ? 4 : 8;
      n32 = n16 + 1 + s16;
      s32 = 2*s16 + 1;
      p16 = rv[14] ? 0 : s16;
      p32 = rv[14] ? 0 : s32;
    end else if (region == 14) begin
      n16 = fmap(int'(rv)); s16 = n16; p16 = n16;
      n32 = 2*n16 + 1; s32 = n32; p32 = n32;
    end
    first = seq ? (wide ? p32 : p16) : (wide ? n32 : n16);
    rest  = wide ? s32 : s16;
    cnt   = (len == 0) ? 1 : len;
    return 1 + first + (cnt - 1) * (1 + rest);
  endfunction

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_model = v;
  endtask

  // mode 0: plain; 1: register write mid-burst; 2: refused request mid-burst
  task automatic do_req(input int region, input bit wide, input bit seq, input int len,
                        input string tag, input int mode, input logic [15:0] newv,
                        output int got);
    int expv = exp_total(cfg_model, region, wide, seq, len);
    int k;
    @(negedge clk);
    check(req_ready == 1'b1, {tag, " R10 idle ready"}, int'(req_ready), 1);
    req_valid = 1'b1; req_region = 4'(region); req_wide = wide;
    req_seq = seq; req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    check(int'(cost_total) == expv, {tag, " R11 total"}, int'(cost_total), expv);
    while (!bus_rdy && k < 6000) begin
      if (mode == 1 && k == 2) begin cfg_we = 1'b1; cfg_data = newv; end
      if (mode == 1 && k == 3) begin cfg_we = 1'b0; cfg_model = newv; end
      if (mode == 2 && k == 2) begin
        req_valid = 1'b1; req_region = 4'd0; req_len = '0; req_wide = 1'b0;
      end
      if (mode == 2 && (k == 2 || k == 3))
        check(req_ready == 1'b0, "R10 ready low while busy", int'(req_ready), 0);
      if (mode == 2 && k == 4) req_valid = 1'b0;
      @(negedge clk);
      k++;
    end
    got = k;
    check(k == expv, {tag, " R11 pulse cycle"}, k, expv);
    @(negedge clk);
    check(bus_rdy == 1'b0, {tag, " R11 single pulse"}, int'(bus_rdy), 0);
    check(req_ready == 1'b1, {tag, " R10 ready after"}, int'(req_ready), 1);
    if (mode == 1)
      check(int'(cost_total) == expv, "R12 latched total held", int'(cost_total), expv);
    if (mode == 2) begin
      int pulses = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (bus_rdy) pulses++;
      end
      check(pulses == 0 && int'(cost_total) == expv, "R10 refused request not taken",
            int'(cost_total), expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int got, got2, seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(bus_rdy == 1'b0, "R1 reset bus_rdy", int'(bus_rdy), 0);
    check(req_ready == 1'b1, "R1 reset req_ready", int'(req_ready), 1);
    check(cost_total == '0, "R1 reset total", int'(cost_total), 0);
    do_req(8, 1, 0, 1, "R1 default region8 wide", 0, 0, got);
    check(got == 8, "R1 default cost", got, 8);

    // R2 field positions and code map
    for (int w = 0; w < 3; w++)
      for (int c = 0; c < 4; c++) begin
        write_cfg(16'(c << (2 + 3*w)));
        do_req(8 + 2*w, 0, 0, 1, "R2 first-access code", 0, 0, got);
        check(got == 1 + fmap(c), "R2 code map", got, 1 + fmap(c));
      end

    // R3 sequential bit per window
    for (int w = 0; w < 3; w++) begin
      write_cfg(16'h0000);
      do_req(9 + 2*w, 0, 0, 2, "R3 seq bit clear", 0, 0, got);
      write_cfg(16'(1 << (4 + 3*w)));
      do_req(9 + 2*w, 0, 0, 2, "R3 seq bit set", 0, 0, got);
    end

    // R4 32-bit derivations
    write_cfg(16'h0367);
    do_req(10, 1, 0, 3, "R4 wide window1", 0, 0, got);
    do_req(12, 1, 0, 4, "R4 wide window2", 0, 0, got);

    // R5 SRAM
    for (int c = 0; c < 4; c++) begin
      write_cfg(16'(c));
      do_req(14, 0, 0, 2, "R5 sram narrow", 0, 0, got);
      do_req(14, 1, 1, 2, "R5 sram wide", 0, 0, got);
    end

    // R6 prefetch
    write_cfg(16'h0000);
    do_req(12, 1, 1, 1, "R6 prefetch off", 0, 0, got);
    check(got == 18, "R6 prefetch off cost", got, 18);
    write_cfg(16'h4000);
    do_req(12, 1, 1, 1, "R6 prefetch on", 0, 0, got);
    check(got == 1, "R6 prefetch on cost", got, 1);
    do_req(8, 0, 1, 3, "R6 prefetch on narrow", 0, 0, got);

    // R7 length corners
    write_cfg(16'h0000);
    do_req(12, 1, 0, 0, "R7 len zero", 0, 0, got);
    do_req(12, 1, 0, 1, "R7 len one", 0, 0, got2);
    check(got == got2, "R7 zero equals one", got, got2);
    do_req(12, 1, 0, 255, "R7 len max", 0, 0, got);

    // R8 internal regions ignore the register
    write_cfg(16'hFFFF);
    do_req(2, 0, 0, 1, "R8 region2 narrow", 0, 0, got);
    check(got == 3, "R8 region2 fixed", got, 3);
    do_req(2, 1, 0, 2, "R8 region2 wide", 0, 0, got);
    do_req(0, 1, 0, 1, "R8 region0", 0, 0, got);
    check(got == 1, "R8 region0 zero", got, 1);
    do_req(15, 0, 1, 5, "R8 region15", 0, 0, got);

    // R9 aliases
    write_cfg(16'h02A5);
    for (int w = 0; w < 3; w++) begin
      do_req(8 + 2*w, 1, 0, 3, "R9 primary", 0, 0, got);
      do_req(9 + 2*w, 1, 0, 3, "R9 extended", 0, 0, got2);
      check(got == got2, "R9 alias equal", got2, got);
    end

    // R12 mid-burst write, then the new costs apply
    write_cfg(16'h0000);
    do_req(12, 1, 0, 4, "R12 burst across write", 1, 16'h070C, got);
    do_req(12, 1, 0, 4, "R12 new costs used", 0, 0, got);
    check(got == 1 + 13 + 3*18 - 0 - 3*(18-18) - 13 + (8+1+1) - 3*18 + 3*4,
          "R12 new cost value", got, 23);

    // R10 refused request while busy
    write_cfg(16'h0000);
    do_req(12, 1, 0, 3, "R10 busy refusal", 2, 0, got);

    // random mix
    for (int i = 0; i < 150; i++) begin
      if (($urandom % 4) == 0) write_cfg(16'($urandom));
      do_req(int'($urandom % 16), 1'($urandom), 1'($urandom), int'($urandom % 21),
             "R7 random burst", 0, 0, got);
    end

    finish_run();
  end
endmodule